// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block sits between a synchronous host and an external 64K-word by 16-bit asynchronous static RAM with a shared data bus. The host presents one request at a time: an address, a read or write flag, a two-bit byte-lane mask and write data, under a valid/ready handshake. The controller turns each request into a sequence of pin-level phases on the memory's active-low chip select, output gate, write strobe and the two byte-lane selects. For reads it returns the word with a one-clock valid pulse.

Every phase lasts a whole number of clock cycles. Each length is derived at elaboration from nanosecond limits and the clock period, so a slower memory grade only needs new parameter values. All strobes come straight from flops, so they cannot glitch. The data bus is driven only inside the write-strobe-low window. It always starts one cycle after the strobe falls, and it is only driven after the memory's output drivers have had time to float following a read.

Top module: `asram_ctl`

## Requirements
- R1: After reset, and whenever the controller is idle, chip select, output gate, write strobe and both lane selects are high (deasserted), the data bus is not driven and `req_ready` is 1.
- R2: A read drives chip select and output gate low and the write strobe high, and presents the request address. Lane select low is taken from mask bit 0 for bits 7:0 (`sram_lb_n`) and from mask bit 1 for bits 15:8 (`sram_ub_n`). The data is sampled only after both ceil(55/P) cycles from address and chip select and ceil(25/P) cycles from output gate have passed.
- R3: The read response `rsp_valid` is high for exactly one clock. Lanes whose mask bit is 0 are returned as zero. A mask of 00 returns 0x0000.
- R4: A write spends one setup cycle with chip select and the selected lane selects low and the write strobe high. It then holds the write strobe low for max(ceil(40/P), ceil(45/P)-1, 1+ceil(25/P)) cycles, which is 4 at P=10 ns. Only lanes whose mask bit is 1 are written. A mask of 00 writes nothing.
- R5: Address and lane selects do not change while chip select and write strobe are both low.
- R6: The data bus is driven only while the write strobe is low, the output gate is high and chip select is low. It is never driven in the first cycle of the strobe-low window, so the data is valid for at least 25 ns before the strobe rises.
- R7: After a read, the output gate stays high for at least ceil(20/P) cycles before the data bus is driven. `req_ready` is 0 from the cycle after acceptance until the access has completed.
- R8: Read data arrives max(ceil(55/P), ceil(25/P)) cycles after acceptance (6 at P=10). A read occupies that many cycles plus ceil(20/P) float cycles (8 in total). A write occupies 1 + strobe cycles + max(1, ceil(55/P) - 1 - strobe cycles) cycles (6 in total).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and accepting |
| req_addr | input | 16 | Word address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_mask | input | 2 | Byte-lane mask, bit 0 = bits 7:0, bit 1 = bits 15:8 |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | One-clock read data valid |
| rsp_rdata | output | 16 | Read data, unselected lanes zero |
| sram_addr | output | 16 | Memory address pins |
| sram_ce_n | output | 1 | Chip select, active low |
| sram_oe_n | output | 1 | Output gate, active low |
| sram_we_n | output | 1 | Write strobe, active low |
| sram_ub_n | output | 1 | Upper lane select, active low |
| sram_lb_n | output | 1 | Lower lane select, active low |
| sram_dq_out | output | 16 | Data toward the memory |
| sram_dq_oe | output | 1 | Data bus drive enable |
| sram_dq_in | input | 16 | Data from the memory |

## Verification
The bench model of the memory returns a marker pattern on any lane that is sampled before its access time or while that lane is deselected. A premature sample or a lost lane mask therefore shows up as a wrong word. Words are first filled with full-word writes and then overwritten with every lane mask in turn. Each word is then read back under all four masks. This separates lane-select mapping faults, missing masking of the response, and writes that wrongly touch an unselected lane. A read followed directly by a write and a read of the same word checks the bus turnaround. The model also measures the strobe pulse width and the data setup time on every write.

// File: rtl/asram_pkg.sv
package asram_pkg;

    localparam int AW    = 16;
    localparam int DW    = 16;
    localparam int LANES = DW / 8;

    // Cycles needed to cover a nanosecond limit, never less than one.
    function automatic int ns2cyc(input int ns, input int per);
        int c;
        c = (ns + per - 1) / per;
        if (c < 1) c = 1;
        return c;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_ACC,
        ST_RD_FLOAT,
        ST_WR_SETUP,
        ST_WR_PULSE,
        ST_WR_RECOV
    } ctl_state_e;

    typedef struct packed {
        ctl_state_e         state;
        logic [AW-1:0]      addr;
        logic               ce_n;
        logic               oe_n;
        logic               we_n;
        logic [LANES-1:0]   be_n;
        logic [LANES-1:0]   mask;
        logic               dq_oe;
        logic [DW-1:0]      wdata;
        logic               rsp_valid;
        logic [DW-1:0]      rdata;
    } ctl_regs_t;

endpackage

// File: rtl/asram_timer.sv
module asram_timer #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          done
);

    logic [CW-1:0] cnt_d;
    logic [CW-1:0] cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign done = (cnt_q == '0);

endmodule

// File: rtl/asram_lane_mask.sv
module asram_lane_mask
    import asram_pkg::*;
(
    input  logic [LANES-1:0] keep,
    input  logic [DW-1:0]    din,
    output logic [DW-1:0]    dout
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign dout[g*8 +: 8] = keep[g] ? din[g*8 +: 8] : 8'h00;
    end

endmodule

// File: rtl/asram_ctl.sv
module asram_ctl
    import asram_pkg::*;
#(
    parameter int CLK_PERIOD_NS = 10,
    parameter int T_RC_NS       = 55,
    parameter int T_AA_NS       = 55,
    parameter int T_OE_NS       = 25,
    parameter int T_HZ_NS       = 20,
    parameter int T_WP_NS       = 40,
    parameter int T_AW_NS       = 45,
    parameter int T_BW_NS       = 45,
    parameter int T_DW_NS       = 25
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [15:0]   req_addr,
    input  logic          req_write,
    input  logic [1:0]    req_mask,
    input  logic [15:0]   req_wdata,
    output logic          rsp_valid,
    output logic [15:0]   rsp_rdata,
    output logic [15:0]   sram_addr,
    output logic          sram_ce_n,
    output logic          sram_oe_n,
    output logic          sram_we_n,
    output logic          sram_ub_n,
    output logic          sram_lb_n,
    output logic [15:0]   sram_dq_out,
    output logic          sram_dq_oe,
    input  logic [15:0]   sram_dq_in
);

    localparam int SU_CYC  = 1;
    localparam int RD_CYC  = imax(imax(ns2cyc(T_AA_NS, CLK_PERIOD_NS),
                                       ns2cyc(T_OE_NS, CLK_PERIOD_NS)),
                                  ns2cyc(T_RC_NS, CLK_PERIOD_NS));
    localparam int HZ_CYC  = ns2cyc(T_HZ_NS, CLK_PERIOD_NS);
    localparam int WE_CYC  = imax(imax(ns2cyc(T_WP_NS, CLK_PERIOD_NS),
                                       ns2cyc(T_AW_NS, CLK_PERIOD_NS) - SU_CYC),
                                  imax(ns2cyc(T_BW_NS, CLK_PERIOD_NS) - SU_CYC,
                                       1 + ns2cyc(T_DW_NS, CLK_PERIOD_NS)));
    localparam int REC_CYC = imax(1, ns2cyc(T_RC_NS, CLK_PERIOD_NS) - SU_CYC - WE_CYC);
    localparam int MAX_CYC = imax(imax(RD_CYC, HZ_CYC), imax(WE_CYC, REC_CYC));
    localparam int CW      = imax(1, $clog2(MAX_CYC + 1));

    ctl_regs_t       r_q;
    ctl_regs_t       r_d;
    logic            t_load;
    logic [CW-1:0]   t_val;
    logic            t_done;
    logic [DW-1:0]   rd_masked;

    asram_timer #(.CW(CW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (t_load),
        .load_val (t_val),
        .done     (t_done)
    );

    asram_lane_mask u_rmask (
        .keep (r_q.mask),
        .din  (sram_dq_in),
        .dout (rd_masked)
    );

    always_comb begin
        r_d           = r_q;
        r_d.rsp_valid = 1'b0;
        t_load        = 1'b0;
        t_val         = '0;

        case (r_q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.addr = req_addr;
                    r_d.mask = req_mask;
                    r_d.be_n = ~req_mask;
                    r_d.ce_n = 1'b0;
                    t_load   = 1'b1;
                    if (req_write) begin
                        r_d.state = ST_WR_SETUP;
                        r_d.wdata = req_wdata;
                        t_val     = CW'(SU_CYC - 1);
                    end else begin
                        r_d.state = ST_RD_ACC;
                        r_d.oe_n  = 1'b0;
                        t_val     = CW'(RD_CYC - 1);
                    end
                end
            end

            ST_RD_ACC: begin
                if (t_done) begin
                    r_d.rdata     = rd_masked;
                    r_d.rsp_valid = 1'b1;
                    r_d.ce_n      = 1'b1;
                    r_d.oe_n      = 1'b1;
                    r_d.be_n      = '1;
                    r_d.state     = ST_RD_FLOAT;
                    t_load        = 1'b1;
                    t_val         = CW'(HZ_CYC - 1);
                end
            end

            ST_RD_FLOAT: begin
                if (t_done) begin
                    r_d.state = ST_IDLE;
                end
            end

            ST_WR_SETUP: begin
                if (t_done) begin
                    r_d.we_n  = 1'b0;
                    r_d.state = ST_WR_PULSE;
                    t_load    = 1'b1;
                    t_val     = CW'(WE_CYC - 1);
                end
            end

            ST_WR_PULSE: begin
                r_d.dq_oe = 1'b1;
                if (t_done) begin
                    r_d.we_n  = 1'b1;
                    r_d.ce_n  = 1'b1;
                    r_d.be_n  = '1;
                    r_d.dq_oe = 1'b0;
                    r_d.state = ST_WR_RECOV;
                    t_load    = 1'b1;
                    t_val     = CW'(REC_CYC - 1);
                end
            end

            ST_WR_RECOV: begin
                if (t_done) begin
                    r_d.state = ST_IDLE;
                end
            end

            default: begin
                r_d.state = ST_IDLE;
                r_d.ce_n  = 1'b1;
                r_d.oe_n  = 1'b1;
                r_d.we_n  = 1'b1;
                r_d.be_n  = '1;
                r_d.dq_oe = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state     <= ST_IDLE;
            r_q.addr      <= '0;
            r_q.ce_n      <= 1'b1;
            r_q.oe_n      <= 1'b1;
            r_q.we_n      <= 1'b1;
            r_q.be_n      <= '1;
            r_q.mask      <= '0;
            r_q.dq_oe     <= 1'b0;
            r_q.wdata     <= '0;
            r_q.rsp_valid <= 1'b0;
            r_q.rdata     <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign req_ready   = (r_q.state == ST_IDLE);
    assign rsp_valid   = r_q.rsp_valid;
    assign rsp_rdata   = r_q.rdata;
    assign sram_addr   = r_q.addr;
    assign sram_ce_n   = r_q.ce_n;
    assign sram_oe_n   = r_q.oe_n;
    assign sram_we_n   = r_q.we_n;
    assign sram_lb_n   = r_q.be_n[0];
    assign sram_ub_n   = r_q.be_n[LANES-1];
    assign sram_dq_out = r_q.wdata;
    assign sram_dq_oe  = r_q.dq_oe;

endmodule

// File: rtl/asram_ctl_chk.sv
module asram_ctl_chk #(
    parameter int CLK_PERIOD_NS = 10,
    parameter int T_AA_NS       = 55,
    parameter int T_WP_NS       = 40,
    parameter int T_HZ_NS       = 20
) (
    input logic        clk,
    input logic        rst_n,
    input logic        req_ready,
    input logic        rsp_valid,
    input logic [15:0] sram_addr,
    input logic        sram_ce_n,
    input logic        sram_oe_n,
    input logic        sram_we_n,
    input logic        sram_ub_n,
    input logic        sram_lb_n,
    input logic        sram_dq_oe
);

    logic [7:0] we_lo_cnt;
    logic [7:0] oe_hi_cnt;
    logic [7:0] ce_lo_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            we_lo_cnt <= '0;
            oe_hi_cnt <= '0;
            ce_lo_cnt <= '0;
        end else begin
            we_lo_cnt <= !sram_we_n ? ((we_lo_cnt == 8'hFF) ? we_lo_cnt : we_lo_cnt + 8'd1) : 8'd0;
            oe_hi_cnt <= sram_oe_n ? ((oe_hi_cnt == 8'hFF) ? oe_hi_cnt : oe_hi_cnt + 8'd1) : 8'd0;
            ce_lo_cnt <= !sram_ce_n ? ((ce_lo_cnt == 8'hFF) ? ce_lo_cnt : ce_lo_cnt + 8'd1) : 8'd0;
        end
    end

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (sram_ce_n && sram_oe_n && sram_we_n && !sram_dq_oe));

    p_no_oe_we_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(!sram_oe_n && !sram_we_n));

    p_rd_wait_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rsp_valid) |-> (int'(ce_lo_cnt) * CLK_PERIOD_NS >= T_AA_NS));

    p_rsp_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    p_we_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sram_we_n) |-> (int'(we_lo_cnt) * CLK_PERIOD_NS >= T_WP_NS));

    p_addr_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!sram_ce_n && !sram_we_n && $past(!sram_ce_n && !sram_we_n))
        |-> ($stable(sram_addr) && $stable(sram_lb_n) && $stable(sram_ub_n)));

    p_drive_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sram_dq_oe |-> (!sram_we_n && !sram_ce_n && sram_oe_n));

    p_drive_late_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sram_we_n) |-> !sram_dq_oe);

    p_float_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sram_dq_oe) |-> (int'(oe_hi_cnt) * CLK_PERIOD_NS >= T_HZ_NS));

endmodule

bind asram_ctl asram_ctl_chk #(
    .CLK_PERIOD_NS (CLK_PERIOD_NS),
    .T_AA_NS       (T_AA_NS),
    .T_WP_NS       (T_WP_NS),
    .T_HZ_NS       (T_HZ_NS)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_ready  (req_ready),
    .rsp_valid  (rsp_valid),
    .sram_addr  (sram_addr),
    .sram_ce_n  (sram_ce_n),
    .sram_oe_n  (sram_oe_n),
    .sram_we_n  (sram_we_n),
    .sram_ub_n  (sram_ub_n),
    .sram_lb_n  (sram_lb_n),
    .sram_dq_oe (sram_dq_oe)
);

// File: tb/asram_ctl_tb_top.sv
`timescale 1ns/1ps
module asram_ctl_tb_top;

    localparam int P       = 10;
    localparam int C_RC    = (55 + P - 1) / P;
    localparam int C_OE    = (25 + P - 1) / P;
    localparam int C_HZ    = (20 + P - 1) / P;
    localparam int C_WP    = (40 + P - 1) / P;
    localparam int C_AW    = (45 + P - 1) / P - 1;
    localparam int C_DW    = 1 + (25 + P - 1) / P;
    localparam int RD_LAT  = (C_RC > C_OE) ? C_RC : C_OE;
    localparam int WE_EXP  = (C_WP > C_AW) ? ((C_WP > C_DW) ? C_WP : C_DW) : ((C_AW > C_DW) ? C_AW : C_DW);
    localparam int REC_EXP = (C_RC - 1 - WE_EXP > 1) ? (C_RC - 1 - WE_EXP) : 1;
    localparam int WR_TOT  = 1 + WE_EXP + REC_EXP;
    localparam int RD_TOT  = RD_LAT + C_HZ;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [15:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic [1:0]  req_mask = '0;
    logic [15:0] req_wdata = '0;
    logic        rsp_valid;
    logic [15:0] rsp_rdata;
    logic [15:0] sram_addr;
    logic        sram_ce_n, sram_oe_n, sram_we_n, sram_ub_n, sram_lb_n;
    logic [15:0] sram_dq_out;
    logic        sram_dq_oe;
    logic [15:0] sram_dq_in = 16'h5A5A;

    always #5 clk = ~clk;

    asram_ctl dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_write(req_write), .req_mask(req_mask), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .sram_addr(sram_addr), .sram_ce_n(sram_ce_n), .sram_oe_n(sram_oe_n),
        .sram_we_n(sram_we_n), .sram_ub_n(sram_ub_n), .sram_lb_n(sram_lb_n),
        .sram_dq_out(sram_dq_out), .sram_dq_oe(sram_dq_oe), .sram_dq_in(sram_dq_in)
    );

    int total = 0;
    int bad   = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s act=0x%0h exp=0x%0h", req, what, act, exp);
        end
    endtask

    // ---------------- memory model ----------------
    logic [15:0] mem    [0:255];
    logic [15:0] shadow [0:255];
    int acc_age, oe_age, we_age, drv_age, oehi_age;
    logic [15:0] pend;
    bit          pend_ok;
    logic [15:0] prev_addr;
    logic        prev_ce, prev_oe, prev_we, prev_dqoe;
    logic [1:0]  prev_be;

    initial begin
        for (int i = 0; i < 256; i++) begin
            mem[i]    = 16'h0000;
            shadow[i] = 16'h0000;
        end
    end

    always @(negedge clk) begin
        logic [1:0]  be;
        logic [15:0] dq;
        be = {sram_ub_n, sram_lb_n};
        if (!rst_n) begin
            acc_age = 100; oe_age = 100; we_age = 0; drv_age = 0; oehi_age = 100;
            pend_ok = 0; pend = '0;
        end else begin
            // write commit on strobe rise
            if (!prev_we && sram_we_n && !prev_ce) begin
                chk(we_age * P >= 40, "R4", "strobe low ns", we_age * P, 40);
                chk(drv_age * P >= 25, "R6", "data setup ns", drv_age * P, 25);
                for (int l = 0; l < 2; l++) begin
                    if (!prev_be[l])
                        mem[prev_addr[7:0]][l*8 +: 8] = pend_ok ? pend[l*8 +: 8] : 8'hEE;
                end
            end
            if (sram_dq_oe && !prev_dqoe)
                chk(oehi_age * P >= 20, "R7", "float ns before drive", oehi_age * P, 20);
            if (sram_dq_oe && !sram_oe_n)
                chk(1'b0, "R6", "bus contention", 1, 0);

            if (!sram_ce_n && !sram_we_n) begin
                we_age++;
                if (sram_dq_oe) begin
                    drv_age++;
                    pend    = sram_dq_out;
                    pend_ok = 1;
                end
            end else begin
                we_age = 0; drv_age = 0; pend_ok = 0;
            end

            if (sram_addr != prev_addr || (!sram_ce_n && prev_ce)) acc_age = 0;
            else if (acc_age < 100) acc_age++;
            if ((!sram_oe_n && prev_oe) || (be & ~prev_be) != 2'b00 || (~be & prev_be) != 2'b00) oe_age = 0;
            else if (oe_age < 100) oe_age++;
            if (sram_oe_n) begin
                if (oehi_age < 100) oehi_age++;
            end else oehi_age = 0;

            for (int l = 0; l < 2; l++) begin
                if (!sram_ce_n && !sram_oe_n && sram_we_n && !be[l]) begin
                    if ((acc_age + 1) * P >= 55 && (oe_age + 1) * P >= 25)
                        dq[l*8 +: 8] = mem[sram_addr[7:0]][l*8 +: 8];
                    else
                        dq[l*8 +: 8] = 8'hC3;
                end else begin
                    dq[l*8 +: 8] = 8'h5A;
                end
            end
            sram_dq_in = dq;
        end
        prev_addr = sram_addr; prev_ce = sram_ce_n; prev_oe = sram_oe_n;
        prev_we = sram_we_n; prev_dqoe = sram_dq_oe; prev_be = be;
    end

    // ---------------- host driver ----------------
    task automatic access(input bit wr, input logic [15:0] a, input logic [1:0] m,
                          input logic [15:0] wd, output logic [15:0] rd,
                          output int rsp_lat, output int busy_lat);
        int k;
        int seen;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1; req_write = wr; req_addr = a; req_mask = m; req_wdata = wd;
        @(negedge clk);
        req_valid = 0;
        k = 1; seen = -1; rsp_lat = -1; rd = '0;
        chk(!req_ready, "R7", "ready while busy", int'(req_ready), 0);
        chk(sram_addr == a, wr ? "R4" : "R2", "address pins", int'(sram_addr), int'(a));
        chk({sram_ub_n, sram_lb_n} == ~m, wr ? "R4" : "R2", "lane selects", int'({sram_ub_n, sram_lb_n}), int'(~m));
        forever begin
            if (rsp_valid && seen < 0) begin
                seen = k; rsp_lat = k - 1; rd = rsp_rdata;
                if (wr) chk(1'b0, "R3", "response on write", 1, 0);
            end else if (seen >= 0 && k == seen + 1) begin
                chk(!rsp_valid, "R3", "valid pulse width", int'(rsp_valid), 0);
            end
            if (req_ready || k > 200) break;
            @(negedge clk);
            k++;
        end
        busy_lat = k - 1;
    endtask

    function automatic logic [15:0] lanes(input logic [15:0] v, input logic [1:0] m);
        return {m[1] ? v[15:8] : 8'h00, m[0] ? v[7:0] : 8'h00};
    endfunction

    initial begin
        logic [15:0] rd;
        int rl, bl;
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(sram_ce_n && sram_oe_n && sram_we_n && sram_ub_n && sram_lb_n, "R1", "strobes after reset",
            int'({sram_ce_n, sram_oe_n, sram_we_n, sram_ub_n, sram_lb_n}), 5'h1F);
        chk(!sram_dq_oe && req_ready && !rsp_valid, "R1", "bus/ready after reset",
            int'({sram_dq_oe, req_ready, rsp_valid}), 3'b010);

        // full-word fill
        for (int a = 0; a < 32; a++) begin
            logic [15:0] d;
            d = {8'(a) ^ 8'hA5, ~8'(a)};
            access(1'b1, 16'(a), 2'b11, d, rd, rl, bl);
            shadow[a] = d;
            chk(bl == WR_TOT, "R8", "write occupancy", bl, WR_TOT);
        end
        // partial overwrites with every mask
        for (int a = 0; a < 32; a++) begin
            logic [15:0] d;
            logic [1:0]  m;
            d = {8'h80 | 8'(a), 8'h40 | 8'(a)};
            m = 2'(a);
            access(1'b1, 16'(a), m, d, rd, rl, bl);
            if (m[0]) shadow[a][7:0]  = d[7:0];
            if (m[1]) shadow[a][15:8] = d[15:8];
        end
        // readback with all masks
        for (int a = 0; a < 32; a++) begin
            for (int mi = 0; mi < 4; mi++) begin
                logic [15:0] e;
                e = lanes(shadow[a], 2'(mi));
                access(1'b0, 16'(a), 2'(mi), 16'h0, rd, rl, bl);
                if (mi == 3) chk(rd == e, "R2", "read word", int'(rd), int'(e));
                else         chk(rd == e, "R3", "masked read", int'(rd), int'(e));
                chk(rl == RD_LAT, "R8", "read latency", rl, RD_LAT);
                chk(bl == RD_TOT, "R8", "read occupancy", bl, RD_TOT);
            end
        end
        // turnaround: read, write, read at a high address
        shadow[8'hFF] = mem[8'hFF];
        access(1'b0, 16'hABFF, 2'b11, 16'h0, rd, rl, bl);
        chk(rd == shadow[8'hFF], "R2", "read before write", int'(rd), int'(shadow[8'hFF]));
        access(1'b1, 16'hABFF, 2'b11, 16'h1234, rd, rl, bl);
        access(1'b1, 16'hABFF, 2'b00, 16'hFFFF, rd, rl, bl);
        access(1'b0, 16'hABFF, 2'b11, 16'h0, rd, rl, bl);
        chk(rd == 16'h1234, "R7", "read after turnaround", int'(rd), 16'h1234);
        chk(rd == 16'h1234, "R4", "empty mask writes nothing", int'(rd), 16'h1234);

        @(negedge clk);
        chk(sram_ce_n && sram_we_n && sram_oe_n && !sram_dq_oe && req_ready, "R1", "idle pins",
            int'({sram_ce_n, sram_we_n, sram_oe_n, sram_dq_oe, req_ready}), 5'b11101);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL R1 watchdog act=hung exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule